// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block closes the feedback path of a fractional-N phase-locked loop. It runs on the output clock of an external dual-modulus prescaler and returns one feedback pulse to the phase detector per comparison period. It also steers the prescaler's modulus-control line with a pulse-swallow counter pair. For a programmed total division N and a prescaler base P (16 or 32), each period lasts B = N / P prescaler cycles. The modulus-control line is high for the first A = N mod P of them. The prescaler therefore divides by P+1 for A cycles and by P for the remaining B−A cycles, so the loop divides the oscillator by P·B + A.

Sub-integer resolution comes from a 4-bit accumulator. At each period boundary it adds a programmable numerator and wraps at 15 or 16, depending on one select bit. When it wraps, the next period counts one extra oscillator cycle, so it uses N+1 in place of N. Averaged over 15 or 16 periods, the division ratio becomes N + num/15 or N + num/16.

All settings are sampled only at a period boundary. An error flag marks settings that the swallow counter pair cannot realise.

Top module: `fracn_fb_div`

## Requirements
- R1: While enabled, `fb_o` is high for exactly one prescaler cycle, the last cycle of each period. With an integer-only setting (numerator 0), each period lasts N / P cycles.
- R2: `mod_ctl_o` is high for the first N mod P cycles of every period and low for the rest. P is 16 when `pre_sel_i` = 0 and 32 when `pre_sel_i` = 1.
- R3: The modulus M is 16 when `frac_mod16_i` = 1 and 15 when it is 0. Every period realises either N or N+1 oscillator cycles, where one period counts P·(period length) + (modulus-control high cycles). Over any M consecutive periods, exactly `frac_num_i` of them realise N+1.
- R4: A change of `n_int_i` in the middle of a period does not alter that period. The new value applies from the next period.
- R5: When the modulus select differs from the value used in the previous period, the accumulator restarts from zero before it adds the numerator for the new period.
- R6: Let B and A be the quotient and remainder of the period's effective division. `cfg_err_o` goes high at a period boundary when B < A, when B = 0, or when `pre_sel_i` = 1 with `n_int_i` below 1056. At any other time it holds its value.
- R7: While `en_i` is low, `fb_o` and `mod_ctl_o` stay low. The first clock edge with `en_i` high starts a fresh period, and the feedback pulse arrives B cycles after that edge.
- R8: While reset is asserted, `fb_o`, `mod_ctl_o` and `cfg_err_o` are low, and the accumulator is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler output clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Run enable; low holds the divider idle |
| n_int_i | input | NW (16) | Integer total division N |
| pre_sel_i | input | 1 | Prescaler base: 0 selects 16/17, 1 selects 32/33 |
| frac_num_i | input | 4 | Fractional numerator |
| frac_mod16_i | input | 1 | Accumulator modulus: 1 selects 16, 0 selects 15 |
| fb_o | output | 1 | One-cycle feedback pulse to the phase detector |
| mod_ctl_o | output | 1 | Prescaler modulus control, high selects P+1 |
| cfg_err_o | output | 1 | Setting cannot be realised by the swallow pair |

## Verification
The main function is exercised with settings that separate its parts. Integer-only settings under both prescaler bases pin down the period length and the swallow count. Non-zero numerators under both moduli check the carry count over a full accumulator cycle. A numerator of 15 with modulus 15 carries on every period. A setting whose carry pushes the remainder over into the quotient (511 + 1 = 512) covers that rollover. Invalid settings cover each error cause: remainder above quotient, and a wide prescaler just below its floor of 1056, next to the exact floor. Directed runs check that the divider ignores a mid-period change, that a modulus switch restarts the accumulator (without the restart the carry pattern differs at once), and that the enable gates the outputs and restarts the count.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int ACC_W       = 4;
  localparam int SWAL_W      = 5;
  localparam int MIN_N_WIDE  = 1056;

  typedef enum logic {
    PRE_16_17 = 1'b0,
    PRE_32_33 = 1'b1
  } pre_sel_e;
endpackage

// File: rtl/fracn_acc.sv
module fracn_acc #(
  parameter int ACC_W = fracn_pkg::ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             mod16,
  input  logic [ACC_W-1:0] num,
  output logic             carry,
  output logic [ACC_W-1:0] acc_q,
  output logic             mod_q
);
  localparam logic [ACC_W:0] FULL = ACC_W'(1) << ACC_W;

  logic [ACC_W-1:0] base, acc_d;
  logic [ACC_W:0]   limit, sum, diff;

  always_comb begin
    base  = (mod16 != mod_q) ? '0 : acc_q;
    limit = mod16 ? FULL : FULL - 1'b1;
    sum   = {1'b0, base} + {1'b0, num};
    diff  = sum - limit;
    carry = (sum >= limit);
    acc_d = carry ? diff[ACC_W-1:0] : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mod_q <= 1'b0;
    end else if (step) begin
      acc_q <= acc_d;
      mod_q <= mod16;
    end
  end
endmodule

// File: rtl/fracn_split.sv
module fracn_split #(
  parameter int NW = 16,
  parameter int AW = fracn_pkg::SWAL_W,
  parameter int BW = NW - 3
) (
  input  logic          [NW-1:0] n_int,
  input  fracn_pkg::pre_sel_e    pre,
  input  logic                   carry,
  output logic          [BW-1:0] b_cnt,
  output logic          [AW-1:0] a_cnt,
  output logic                   bad
);
  logic [NW:0] n_eff;
  logic        floor_low;

  always_comb begin
    n_eff = {1'b0, n_int} + {{NW{1'b0}}, carry};
    if (pre == fracn_pkg::PRE_32_33) begin
      a_cnt = n_eff[4:0];
      b_cnt = {1'b0, n_eff[NW:5]};
    end else begin
      a_cnt = {1'b0, n_eff[3:0]};
      b_cnt = n_eff[NW:4];
    end
    floor_low = (pre == fracn_pkg::PRE_32_33) && (n_int < NW'(fracn_pkg::MIN_N_WIDE));
    bad = (b_cnt < BW'(a_cnt)) || (b_cnt == '0) || floor_low;
  end
endmodule

// File: rtl/fracn_swallow.sv
module fracn_swallow #(
  parameter int BW = 13,
  parameter int AW = fracn_pkg::SWAL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [BW-1:0] b_cnt,
  input  logic [AW-1:0] a_cnt,
  output logic          ld,
  output logic          fb,
  output logic          mod
);
  logic          run_q, run_d;
  logic [BW-1:0] main_q, main_d;
  logic [AW-1:0] swal_q, swal_d;
  logic          main_end;

  assign main_end = (main_q == '0);
  assign ld       = en && (!run_q || main_end);
  assign fb       = run_q && main_end;
  assign mod      = run_q && (swal_q != '0);

  always_comb begin
    run_d  = run_q;
    main_d = main_q;
    swal_d = swal_q;
    if (!en) begin
      run_d  = 1'b0;
      main_d = '0;
      swal_d = '0;
    end else if (ld) begin
      run_d  = 1'b1;
      main_d = b_cnt - 1'b1;
      swal_d = a_cnt;
    end else begin
      main_d = main_q - 1'b1;
      if (swal_q != '0) swal_d = swal_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      main_q <= '0;
      swal_q <= '0;
    end else begin
      run_q  <= run_d;
      main_q <= main_d;
      swal_q <= swal_d;
    end
  end
endmodule

// File: rtl/fracn_fb_div.sv
module fracn_fb_div #(
  parameter int NW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NW-1:0] n_int_i,
  input  logic          pre_sel_i,
  input  logic [3:0]    frac_num_i,
  input  logic          frac_mod16_i,
  output logic          fb_o,
  output logic          mod_ctl_o,
  output logic          cfg_err_o
);
  localparam int ACC_W = fracn_pkg::ACC_W;
  localparam int AW    = fracn_pkg::SWAL_W;
  localparam int BW    = NW - 3;

  logic [1:0]       rst_sync;
  logic             rst_n;
  logic             ld, carry, bad, mod_q;
  logic [ACC_W-1:0] acc_q;
  logic [BW-1:0]    b_cnt;
  logic [AW-1:0]    a_cnt;
  logic             err_q, err_d;
  fracn_pkg::pre_sel_e pre;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  assign pre = fracn_pkg::pre_sel_e'(pre_sel_i);

  fracn_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk_i), .rst_n(rst_n), .step(ld), .mod16(frac_mod16_i),
    .num(frac_num_i), .carry(carry), .acc_q(acc_q), .mod_q(mod_q)
  );

  fracn_split #(.NW(NW), .AW(AW), .BW(BW)) u_split (
    .n_int(n_int_i), .pre(pre), .carry(carry),
    .b_cnt(b_cnt), .a_cnt(a_cnt), .bad(bad)
  );

  fracn_swallow #(.BW(BW), .AW(AW)) u_swal (
    .clk(clk_i), .rst_n(rst_n), .en(en_i), .b_cnt(b_cnt), .a_cnt(a_cnt),
    .ld(ld), .fb(fb_o), .mod(mod_ctl_o)
  );

  always_comb begin
    err_d = err_q;
    if (ld) err_d = bad;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign cfg_err_o = err_q;
endmodule

// File: rtl/fracn_fb_div_chk.sv
module fracn_fb_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       fb,
  input logic       mod,
  input logic       err,
  input logic       ld,
  input logic [3:0] acc,
  input logic       mod16_q
);
  // R7: disabled divider is silent on the next cycle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!fb && !mod));

  // R6: error flag only moves at a period boundary
  a_r6_err_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(err));

  // R2: modulus control can only rise when a new period is loaded
  a_r2_mod_rise_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod && !ld) |=> !mod);

  // R3: accumulator stays below the modulus it was last updated with
  a_r3_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !mod16_q |-> (acc != 4'd15));

  // R8: outputs quiet while reset holds
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_quiet: assert (!fb && !mod && !err && acc == 4'd0);
    end
  end
endmodule

bind fracn_fb_div fracn_fb_div_chk u_chk (
  .clk(clk_i), .rst_n(rst_n), .en(en_i), .fb(fb_o), .mod(mod_ctl_o),
  .err(cfg_err_o), .ld(ld), .acc(acc_q), .mod16_q(mod_q)
);

// File: tb/fracn_fb_div_bench.sv
module fracn_fb_div_bench;
  logic        clk = 1'b0;
  logic        rst_n, en, ps, m16;
  logic [15:0] n;
  logic [3:0]  num;
  logic        fb, mod, err;
  int          nchk = 0, nerr = 0, pdiv = 16;

  always #5 clk = ~clk;

  fracn_fb_div u_fracn_fb_div (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .n_int_i(n), .pre_sel_i(ps),
    .frac_num_i(num), .frac_mod16_i(m16), .fb_o(fb), .mod_ctl_o(mod), .cfg_err_o(err)
  );

  typedef struct packed {
    logic [15:0] n;
    logic        ps;
    logic [3:0]  num;
    logic        m16;
    logic        err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'd325,  1'b0, 4'd0,  1'b1, 1'b0},
    '{16'd325,  1'b0, 4'd5,  1'b1, 1'b0},
    '{16'd1100, 1'b1, 4'd7,  1'b0, 1'b0},
    '{16'd2000, 1'b1, 4'd15, 1'b0, 1'b0},
    '{16'd1056, 1'b1, 4'd3,  1'b1, 1'b0},
    '{16'd511,  1'b0, 4'd9,  1'b0, 1'b0},
    '{16'd1100, 1'b1, 4'd0,  1'b1, 1'b0},
    '{16'd58,   1'b0, 4'd0,  1'b1, 1'b1},
    '{16'd1055, 1'b1, 4'd0,  1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(output int cyc, output int md, output int nk);
    cyc = 0; md = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (mod) md++;
    end while (!fb);
    nk = pdiv * cyc + md;
  endtask

  task automatic do_reset();
    en = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!fb && !mod && !err, "R8 reset outputs", {fb, mod, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_fb();
    do @(negedge clk); while (!fb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int cyc, md, nk, carries, mm;
    bit rng_ok;
    en = 0; rst_n = 0; n = 16'd325; ps = 0; num = 0; m16 = 1;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      n = VECS[i].n; ps = VECS[i].ps; num = VECS[i].num; m16 = VECS[i].m16;
      pdiv = ps ? 32 : 16;
      en = 1'b1;
      @(negedge clk);
      check(err == VECS[i].err, "R6 error flag", err, VECS[i].err);
      if (!VECS[i].err) begin
        wait_fb();
        mm = m16 ? 16 : 15;
        carries = 0; rng_ok = 1;
        for (int k = 0; k < mm; k++) begin
          meas(cyc, md, nk);
          if (nk == int'(n) + 1) carries++;
          else if (nk != int'(n)) rng_ok = 0;
          if (num == 0 && k == 0) begin
            check(cyc == int'(n) / pdiv, "R1 period length", cyc, int'(n) / pdiv);
            check(md == int'(n) % pdiv, "R2 swallow cycles", md, int'(n) % pdiv);
          end
        end
        check(rng_ok, "R3 each period N or N+1", rng_ok, 1);
        check(carries == int'(num), "R3 carries per modulus cycle", carries, num);
      end
      en = 1'b0;
    end

    // R7: enable gating and restart
    do_reset();
    n = 16'd325; ps = 0; num = 0; m16 = 1; pdiv = 16;
    en = 1'b1;
    wait_fb();
    en = 1'b0;
    @(negedge clk);
    begin
      bit quiet = 1;
      repeat (40) begin
        @(negedge clk);
        if (fb || mod) quiet = 0;
      end
      check(quiet, "R7 idle outputs low", quiet, 1);
    end
    en = 1'b1;
    meas(cyc, md, nk);
    check(cyc == 20, "R7 first period after enable", cyc, 20);
    check(md == 5, "R7 swallow in first period", md, 5);

    // R4: mid-period change of integer value
    wait_fb();
    @(negedge clk);
    n = 16'd162;
    cyc = 1; md = mod ? 1 : 0;
    while (!fb) begin
      @(negedge clk);
      cyc++;
      if (mod) md++;
    end
    check(16 * cyc + md == 325, "R4 current period unchanged", 16 * cyc + md, 325);
    meas(cyc, md, nk);
    check(nk == 162, "R4 next period uses new value", nk, 162);

    // R5: modulus switch restarts accumulator
    do_reset();
    n = 16'd325; ps = 0; num = 4'd8; m16 = 1; pdiv = 16;
    en = 1'b1;
    do meas(cyc, md, nk); while (nk != 326);
    meas(cyc, md, nk);
    check(nk == 325, "R3 period after carry", nk, 325);
    m16 = 1'b0; num = 4'd7;
    meas(cyc, md, nk);
    check(nk == 325, "R5 first period after switch", nk, 325);
    meas(cyc, md, nk);
    check(nk == 325, "R5 second period after switch", nk, 325);
    meas(cyc, md, nk);
    check(nk == 326, "R5 third period after switch", nk, 326);

    en = 1'b0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule